// File: doc/BRIEF.md
# Lockable Watchdog Timer with Prescaler

This block is a 16-bit count-down/count-up timer driven by a slow tick enable. The tick comes from a 32.768 kHz source that has already been synchronised into the system clock domain as a one-cycle strobe. A prescaler divides the tick by 1, 16 or 256. In its ordinary role the timer reloads itself from a programmable load value every time it wraps, and it raises a sticky interrupt that software clears by writing the clear register.

Setting the watchdog bit of the control register changes what the block does. The count then always runs downward, and software must write the clear register before the count runs out. If it does not, the block raises either a one-cycle reset request or the interrupt. From that moment the load and control registers are frozen. A system reset no longer touches the timer, so the count carries on through it. Only the power-on reset returns the block to its default state. A capture strobe copies the live count into a separate readable register, but only outside watchdog mode.

Register addresses (3-bit `reg_addr`): 0 = load, 1 = value (read only), 2 = control (8 bits, zero-extended on read), 3 = clear (write only, data ignored), 4 = capture (read only). Control bits:
- bit 7: enable in ordinary mode
- bit 6: count up when 1
- bit 5: watchdog mode
- bit 4: reserved, reads 0
- bits 3:2: prescaler select
- bit 1: expiry raises the interrupt when 1, a reset request when 0
- bit 0: stop counting during power-down

Top module: `lwd_top`

## Requirements
- R1: After `por`, load and value read 0x03D7, control and capture read 0, and `irq` and `rst_req` are low.
- R2: One count step occurs for each accepted tick when control bits 3:2 are 00, every 16 ticks when they are 01, and every 256 ticks when they are 10 or 11.
- R3: In ordinary mode, with bit 7 set and bit 6 clear, each step decrements the value; a step taken at 0 reloads the value from load and sets `irq`.
- R4: In ordinary mode with bit 6 set, each step increments the value; a step taken at 0xFFFF reloads from load and sets `irq`.
- R5: Any write to address 3 reloads the value from load, restarts the prescaler phase and clears `irq` in the next cycle, in either mode.
- R6: With bit 5 set, the value counts down whatever bits 7 and 6 hold. A step taken at 0 reloads from load and raises either a one-cycle `rst_req` pulse (bit 1 = 0) or `irq` (bit 1 = 1). Writing address 3 often enough prevents every such event.
- R7: While bit 5 is set, writes to the load and control addresses leave both registers unchanged.
- R8: `sys_rst` has the same effect as `por` outside watchdog mode. Inside watchdog mode it changes nothing, and counting continues. `por` always resets the block and unlocks it.
- R9: While `dbg_halt` is high, neither the value nor the prescaler phase advances.
- R10: `pwr_down` stops counting only when control bit 0 is 1.
- R11: A `cap_strobe` outside watchdog mode copies the current value into the capture register. Inside watchdog mode the strobe is ignored.
- R12: `reg_rdata` presents the addressed register one cycle after `reg_rd`, and it is 0 in any cycle without a read. Reads of address 3 return 0, and writes to addresses 1 and 4 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por | input | 1 | Power-on reset, synchronous, active high |
| sys_rst | input | 1 | System reset, synchronous, active high, ignored while locked |
| tick | input | 1 | One-cycle strobe from the slow timebase |
| dbg_halt | input | 1 | Pauses counting while high |
| pwr_down | input | 1 | Power-down indication |
| cap_strobe | input | 1 | Copies the count into the capture register |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data |
| irq | output | 1 | Sticky interrupt |
| rst_req | output | 1 | One-cycle reset request from watchdog expiry |

## Verification
The bench builds the block with its default parameters: 16-bit count, a reset load of 0x03D7, and prescaler divisors of 16 and 256. Because the bench holds `tick` high in every cycle, even the /256 setting takes only a few hundred cycles. Bench-written load values near 0 and near 0xFFFF bring both wrap points, watchdog expiry and servicing within a few dozen cycles. With these settings one run covers every prescaler code, both expiry actions, and the lock surviving a system reset until a power-on reset.

// File: rtl/lwd_pkg.sv
package lwd_pkg;

  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADR_LOAD  = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_VALUE = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_CTRL  = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_CLEAR = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_CAPT  = 3'd4;

  localparam logic [7:0] CTRL_WMASK = 8'hEF;

  typedef struct packed {
    logic       run_en;
    logic       dir_up;
    logic       wd_mode;
    logic       rsvd;
    logic [1:0] psel;
    logic       wd_irq;
    logic       pd_stop;
  } ctrl_t;

  localparam logic [1:0] PSEL_DIV1  = 2'b00;
  localparam logic [1:0] PSEL_DIVM  = 2'b01;

endpackage

// File: rtl/lwd_prescaler.sv
module lwd_prescaler #(
  parameter int MID_LOG2 = 4,
  parameter int HI_LOG2  = 8
) (
  input  logic       clk,
  input  logic       clr,
  input  logic       run,
  input  logic       tick,
  input  logic [1:0] psel,
  output logic       step
);
  import lwd_pkg::*;

  localparam int CW = HI_LOG2;
  localparam logic [CW-1:0] LIM_MID = CW'((1 << MID_LOG2) - 1);
  localparam logic [CW-1:0] LIM_HI  = CW'((1 << HI_LOG2) - 1);

  logic [CW-1:0] phase_q;
  logic [CW-1:0] limit;
  logic          adv;

  always_comb begin
    case (psel)
      PSEL_DIV1: limit = '0;
      PSEL_DIVM: limit = LIM_MID;
      default:   limit = LIM_HI;
    endcase
  end

  assign adv  = run & tick;
  assign step = adv & (phase_q >= limit);

  always_ff @(posedge clk) begin
    if (clr)
      phase_q <= '0;
    else if (adv)
      phase_q <= step ? '0 : phase_q + 1'b1;
  end

endmodule

// File: rtl/lwd_counter.sv
module lwd_counter #(
  parameter int          W       = 16,
  parameter logic [W-1:0] RST_VAL = 16'h03D7
) (
  input  logic         clk,
  input  logic         zap,
  input  logic         reload,
  input  logic         step,
  input  logic         wd,
  input  logic         dir_up,
  input  logic         irq_sel,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] value,
  output logic         irq,
  output logic         rst_req
);

  logic up;
  logic at_end;

  assign up     = dir_up & ~wd;
  assign at_end = up ? (value == {W{1'b1}}) : (value == '0);

  always_ff @(posedge clk) begin
    rst_req <= 1'b0;
    if (zap) begin
      value <= RST_VAL;
      irq   <= 1'b0;
    end else if (reload) begin
      value <= load_val;
      irq   <= 1'b0;
    end else if (step) begin
      if (at_end) begin
        value <= load_val;
        if (wd && !irq_sel)
          rst_req <= 1'b1;
        else
          irq <= 1'b1;
      end else if (up) begin
        value <= value + 1'b1;
      end else begin
        value <= value - 1'b1;
      end
    end
  end

endmodule

// File: rtl/lwd_top.sv
module lwd_top #(
  parameter int              CNT_W    = 16,
  parameter logic [CNT_W-1:0] LOAD_RST = 16'h03D7,
  parameter int              MID_LOG2 = 4,
  parameter int              HI_LOG2  = 8
) (
  input  logic             clk,
  input  logic             por,
  input  logic             sys_rst,
  input  logic             tick,
  input  logic             dbg_halt,
  input  logic             pwr_down,
  input  logic             cap_strobe,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [2:0]       reg_addr,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  output logic             irq,
  output logic             rst_req
);
  import lwd_pkg::*;

  localparam int CTRL_W = $bits(ctrl_t);

  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] load_q;
  logic [CNT_W-1:0] cap_q;
  logic [CNT_W-1:0] value_q;
  logic             wd_q;
  logic             zap;
  logic             clr_wr;
  logic             wr_load;
  logic             wr_ctrl;
  logic             run;
  logic             step;

  assign wd_q    = ctrl_q.wd_mode;
  assign zap     = por | (sys_rst & ~wd_q);
  assign clr_wr  = reg_wr & (reg_addr == ADR_CLEAR);
  assign wr_load = reg_wr & (reg_addr == ADR_LOAD) & ~wd_q;
  assign wr_ctrl = reg_wr & (reg_addr == ADR_CTRL) & ~wd_q;
  assign run     = (ctrl_q.run_en | wd_q) & ~dbg_halt & ~(pwr_down & ctrl_q.pd_stop);

  always_ff @(posedge clk) begin
    if (zap) begin
      load_q <= LOAD_RST;
      ctrl_q <= '0;
      cap_q  <= '0;
    end else begin
      if (wr_load)
        load_q <= reg_wdata;
      if (wr_ctrl)
        ctrl_q <= ctrl_t'(reg_wdata[CTRL_W-1:0] & CTRL_WMASK);
      if (cap_strobe && !wd_q)
        cap_q <= value_q;
    end
  end

  always_ff @(posedge clk) begin
    if (zap || !reg_rd) begin
      reg_rdata <= '0;
    end else begin
      case (reg_addr)
        ADR_LOAD:  reg_rdata <= load_q;
        ADR_VALUE: reg_rdata <= value_q;
        ADR_CTRL:  reg_rdata <= {{(CNT_W-CTRL_W){1'b0}}, ctrl_q};
        ADR_CAPT:  reg_rdata <= cap_q;
        default:   reg_rdata <= '0;
      endcase
    end
  end

  lwd_prescaler #(
    .MID_LOG2 (MID_LOG2),
    .HI_LOG2  (HI_LOG2)
  ) u_presc (
    .clk  (clk),
    .clr  (zap | clr_wr),
    .run  (run),
    .tick (tick),
    .psel (ctrl_q.psel),
    .step (step)
  );

  lwd_counter #(
    .W       (CNT_W),
    .RST_VAL (LOAD_RST)
  ) u_cnt (
    .clk      (clk),
    .zap      (zap),
    .reload   (clr_wr),
    .step     (step),
    .wd       (wd_q),
    .dir_up   (ctrl_q.dir_up),
    .irq_sel  (ctrl_q.wd_irq),
    .load_val (load_q),
    .value    (value_q),
    .irq      (irq),
    .rst_req  (rst_req)
  );

endmodule

// File: rtl/lwd_checker.sv
module lwd_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             por,
  input logic             sys_rst,
  input logic             dbg_halt,
  input logic             cap_strobe,
  input logic             clr_wr,
  input logic             wd_q,
  input logic [CNT_W-1:0] load_q,
  input logic [CNT_W-1:0] value_q,
  input logic [CNT_W-1:0] cap_q,
  input logic             irq,
  input logic             rst_req
);

  logic [1:0] since_por;
  logic       hist_ok;

  always_ff @(posedge clk) begin
    if (por)
      since_por <= 2'd0;
    else if (since_por != 2'd2)
      since_por <= since_por + 2'd1;
  end

  assign hist_ok = (since_por == 2'd2);

  AST_LOCK_STAYS: assert property (@(posedge clk) disable iff (por || !hist_ok)
    wd_q |=> wd_q);  // R8
  AST_LOAD_FROZEN: assert property (@(posedge clk) disable iff (por || !hist_ok)
    wd_q |=> $stable(load_q));  // R7
  AST_RST_ONLY_WD: assert property (@(posedge clk) disable iff (por || !hist_ok)
    rst_req |-> wd_q);  // R6
  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (por || !hist_ok)
    (dbg_halt && !clr_wr && !sys_rst) |=> $stable(value_q));  // R9
  AST_CLEAR_DROPS_IRQ: assert property (@(posedge clk) disable iff (por || !hist_ok)
    (clr_wr && !sys_rst) |=> !irq);  // R5
  AST_CAPTURE_TAKES: assert property (@(posedge clk) disable iff (por || !hist_ok)
    (cap_strobe && !wd_q && !sys_rst) |=> (cap_q == $past(value_q)));  // R11

endmodule

bind lwd_top lwd_checker #(.CNT_W(CNT_W)) u_lwd_chk (
  .clk        (clk),
  .por        (por),
  .sys_rst    (sys_rst),
  .dbg_halt   (dbg_halt),
  .cap_strobe (cap_strobe),
  .clr_wr     (clr_wr),
  .wd_q       (wd_q),
  .load_q     (load_q),
  .value_q    (value_q),
  .cap_q      (cap_q),
  .irq        (irq),
  .rst_req    (rst_req)
);

// File: tb/test_lwd_top.sv
`timescale 1ns/1ps
module test_lwd_top;

  logic        clk = 1'b0;
  logic        por = 1'b1;
  logic        sys_rst = 1'b0;
  logic        tick = 1'b0;
  logic        dbg_halt = 1'b0;
  logic        pwr_down = 1'b0;
  logic        cap_strobe = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [15:0] reg_wdata = 16'd0;
  logic [15:0] reg_rdata;
  logic        irq;
  logic        rst_req;

  always #2 clk = ~clk;

  lwd_top i_lwd_top (
    .clk(clk), .por(por), .sys_rst(sys_rst), .tick(tick), .dbg_halt(dbg_halt),
    .pwr_down(pwr_down), .cap_strobe(cap_strobe), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .rst_req(rst_req)
  );

  int    n_chk = 0;
  int    n_fail = 0;
  int    rst_cnt = 0;
  bit    started = 0;
  bit    done = 0;
  string cur_req = "R1";

  // behavioural reference state
  int m_load, m_ctrl, m_val, m_cap, m_pc, m_rdata;
  bit m_irq, m_rst;

  always @(posedge clk) begin
    int  lim, nval, npc, ncap, nload, nctrl, nrd;
    bit  wd, zap, run, stp, up, clr, nirq, nrst;
    wd  = m_ctrl[5];
    zap = por || (sys_rst && !wd);
    clr = reg_wr && reg_addr == 3;
    nrd = 0;
    if (!zap && reg_rd) begin
      case (reg_addr)
        0: nrd = m_load;
        1: nrd = m_val;
        2: nrd = m_ctrl;
        4: nrd = m_cap;
        default: nrd = 0;
      endcase
    end
    if (zap) begin
      m_load = 16'h03D7; m_val = 16'h03D7; m_ctrl = 0; m_cap = 0;
      m_pc = 0; m_irq = 0; m_rst = 0;
    end else begin
      run = (m_ctrl[7] || wd) && !dbg_halt && !(pwr_down && m_ctrl[0]);
      case ((m_ctrl >> 2) & 3)
        0: lim = 0;
        1: lim = 15;
        default: lim = 255;
      endcase
      stp  = run && tick && (m_pc >= lim);
      npc  = clr ? 0 : (run && tick) ? (stp ? 0 : m_pc + 1) : m_pc;
      nval = m_val; nirq = m_irq; nrst = 0;
      up   = m_ctrl[6] && !wd;
      if (clr) begin
        nval = m_load; nirq = 0;
      end else if (stp) begin
        if ((up && m_val == 65535) || (!up && m_val == 0)) begin
          nval = m_load;
          if (wd && !m_ctrl[1]) nrst = 1; else nirq = 1;
        end else begin
          nval = up ? m_val + 1 : m_val - 1;
        end
      end
      ncap  = (cap_strobe && !wd) ? m_val : m_cap;
      nload = (reg_wr && reg_addr == 0 && !wd) ? int'(reg_wdata) : m_load;
      nctrl = (reg_wr && reg_addr == 2 && !wd) ? int'(reg_wdata[7:0] & 8'hEF) : m_ctrl;
      m_val = nval; m_irq = nirq; m_rst = nrst; m_pc = npc; m_cap = ncap;
      m_load = nload; m_ctrl = nctrl;
    end
    m_rdata = nrd;
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      chk({cur_req, " irq"}, int'(irq), int'(m_irq));
      chk({cur_req, " rst_req"}, int'(rst_req), int'(m_rst));
      chk({cur_req, " rdata"}, int'(reg_rdata), m_rdata);
      if (rst_req) rst_cnt++;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd_exp(input logic [2:0] a, input int exp, input string tag);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0;
    chk(tag, int'(reg_rdata), exp);
  endtask

  task automatic rd(input logic [2:0] a);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(4 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    idle(3);
    por = 1'b0;
    started = 1;
    // R1 reset state
    cur_req = "R1";
    rd_exp(3'd0, 16'h03D7, "R1 load");
    rd_exp(3'd1, 16'h03D7, "R1 value");
    rd_exp(3'd2, 0, "R1 ctrl");
    rd_exp(3'd4, 0, "R1 capture");
    chk("R1 irq", int'(irq), 0);

    // R3 down count, wrap at 0
    cur_req = "R3";
    tick = 1'b1;
    wr(3'd0, 16'd5);
    wr(3'd2, 16'h0080);
    wr(3'd3, 16'h0000);
    idle(12);
    chk("R3 irq set", int'(irq), 1);
    rd(3'd1);
    // R5 clear drops irq and reloads
    cur_req = "R5";
    wr(3'd3, 16'h00A5);
    chk("R5 irq cleared", int'(irq), 0);
    idle(3);

    // R4 up count, wrap at 0xFFFF
    cur_req = "R4";
    wr(3'd0, 16'hFFF0);
    wr(3'd2, 16'h00C0);
    wr(3'd3, 16'h0000);
    idle(30);
    chk("R4 irq set", int'(irq), 1);
    rd(3'd1);

    // R2 prescaler codes
    cur_req = "R2";
    wr(3'd0, 16'd3);
    wr(3'd2, 16'h0084);
    wr(3'd3, 16'h0000);
    repeat (6) begin idle(20); rd(3'd1); end
    wr(3'd2, 16'h0088);
    wr(3'd3, 16'h0000);
    repeat (6) begin idle(200); rd(3'd1); end
    wr(3'd2, 16'h008C);
    wr(3'd3, 16'h0000);
    repeat (3) begin idle(150); rd(3'd1); end

    // R9 debug halt
    cur_req = "R9";
    wr(3'd0, 16'd100);
    wr(3'd2, 16'h0084);
    wr(3'd3, 16'h0000);
    idle(7);
    dbg_halt = 1'b1;
    rd(3'd1); idle(40); rd(3'd1);
    dbg_halt = 1'b0;
    idle(20); rd(3'd1);

    // R10 power-down gating
    cur_req = "R10";
    wr(3'd2, 16'h0080);
    pwr_down = 1'b1;
    idle(5); rd(3'd1);
    wr(3'd2, 16'h0081);
    rd(3'd1); idle(10); rd(3'd1);
    pwr_down = 1'b0;
    idle(4); rd(3'd1);

    // R11 capture outside watchdog
    cur_req = "R11";
    @(negedge clk); cap_strobe = 1'b1;
    @(negedge clk); cap_strobe = 1'b0;
    rd(3'd4);

    // R12 read-only / write-only registers
    cur_req = "R12";
    wr(3'd1, 16'h1234);
    wr(3'd4, 16'h5678);
    rd(3'd1);
    rd(3'd4);
    rd_exp(3'd3, 0, "R12 clear reads zero");
    rd_exp(3'd2, 16'h0081, "R12 ctrl readback");

    // R8 system reset outside watchdog
    cur_req = "R8";
    wr(3'd0, 16'h0020);
    @(negedge clk); sys_rst = 1'b1;
    @(negedge clk); sys_rst = 1'b0;
    rd_exp(3'd0, 16'h03D7, "R8 load reset by sys_rst");
    rd_exp(3'd2, 0, "R8 ctrl reset by sys_rst");

    // R6 watchdog with reset request
    cur_req = "R6";
    wr(3'd0, 16'd10);
    wr(3'd2, 16'h0060);
    wr(3'd3, 16'h0000);
    rst_cnt = 0;
    idle(30);
    chk("R6 expiry pulses", int'(rst_cnt >= 2), 1);
    rst_cnt = 0;
    repeat (8) begin wr(3'd3, 16'h0000); idle(3); end
    chk("R6 serviced no pulse", rst_cnt, 0);

    // R7 lock
    cur_req = "R7";
    wr(3'd0, 16'h0100);
    wr(3'd2, 16'h0000);
    rd_exp(3'd0, 10, "R7 load locked");
    rd_exp(3'd2, 16'h0060, "R7 ctrl locked");
    wr(3'd3, 16'h0000);

    // R11 capture ignored in watchdog
    cur_req = "R11";
    @(negedge clk); cap_strobe = 1'b1;
    @(negedge clk); cap_strobe = 1'b0;
    rd(3'd4);

    // R8 system reset inside watchdog
    cur_req = "R8";
    @(negedge clk); sys_rst = 1'b1;
    @(negedge clk); sys_rst = 1'b0;
    rd_exp(3'd0, 10, "R8 load kept through sys_rst");
    rd_exp(3'd2, 16'h0060, "R8 lock kept through sys_rst");
    rst_cnt = 0;
    idle(25);
    chk("R8 count continues", int'(rst_cnt >= 1), 1);
    @(negedge clk); por = 1'b1;
    @(negedge clk); por = 1'b0;
    rd_exp(3'd2, 0, "R8 por unlocks");

    // R6 watchdog with interrupt
    cur_req = "R6";
    wr(3'd0, 16'd8);
    wr(3'd2, 16'h0022);
    wr(3'd3, 16'h0000);
    rst_cnt = 0;
    idle(20);
    chk("R6 irq on expiry", int'(irq), 1);
    chk("R6 no rst in irq mode", rst_cnt, 0);
    idle(2);
    finish_run();
  end

endmodule